// File: doc/BRIEF.md
# Channel Control and Error-Status Unit

This unit tracks the state of one data-processing channel in a co-processor and exposes a single 32-bit control/status word over a simple register bus. A dispatcher hands the channel work descriptors. Each descriptor carries an opcode, a source address, a destination address and a byte count. The unit accepts a descriptor only while the channel is idle. It screens the opcode and the alignment of the descriptor in the cycle of acceptance. A clean descriptor moves the channel to busy and is passed on, registered, to the data path. A faulty descriptor sets a sticky error flag and parks the channel in the error state.

Software can also request a channel role through the control word. Two requests are illegal: asking for the chaining-master role, and asking to be couple-master and slave at the same time. Either one raises a sticky configuration fault. A self-clearing command bit performs a partial, synchronous soft reset. It wipes the status byte and the tag byte, returns the channel to idle, aborts work in flight and strobes a FIFO flush. The role and scratch fields are left as they were. An active-low asynchronous master reset clears everything.

Top module: `chan_ctrl`

## Requirements
- R1: The channel state sits in word bits 31:30, encoded 00 idle, 01 busy, 10 error. When a descriptor is accepted while the channel is idle and the descriptor is clean, the state becomes busy. In the following cycle exec_go pulses for one cycle, and exec_op, exec_src, exec_dst and exec_cnt carry the descriptor. A done_in pulse while the channel is busy returns it to idle and sets the completion flag, bit 24.
- R2: ins_ready is high only in the idle state. A descriptor presented while the channel is busy or in error is dropped without effect.
- R3: An accepted opcode of 0, or an opcode above NUM_OPS (default 5), sets the decode-fault flag (bit 26) and moves the channel to the error state.
- R4: If the low two bits of the source address, of the destination address or of the byte count are not zero, the alignment-fault flag (bit 25) is set and the channel moves to the error state.
- R5: A register write with bit 16 clear is a role request. If it sets bit 8 (chaining master), or sets bits 9 (couple master) and 10 (slave) together, the configuration-fault flag (bit 27) is set and the channel moves to the error state. Bits 10:8 are stored as written.
- R6: Flags 27:24 are sticky. Later writes, later descriptors and done_in pulses do not clear them.
- R7: A write with bit 16 set is a soft reset, and the other bits of that write are discarded. In the next cycle bits 29:24 and 7:0 are zero and the state is idle, while bits 15:8 keep their values. Bit 16 always reads 0. A write with bit 16 clear performs no reset.
- R8: A soft reset pulses fifo_flush for exactly one cycle. It also pulses exec_abort if the channel was busy.
- R9: Bits 23:17 and 29:28 read as zero. Writes to bits 31:17 have no effect.
- R10: While mrst_n is low, every field, the state, bus_rdata and all pulse outputs are zero, whatever the clock is doing.
- R11: The control word is at address 0. A read returns data on bus_rdata one cycle after bus_re. Other addresses read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ins_valid | input | 1 | Descriptor valid from dispatcher |
| ins_ready | output | 1 | Channel idle and able to take a descriptor |
| ins_op | input | OP_W | Descriptor opcode |
| ins_src | input | AW | Descriptor source address |
| ins_dst | input | AW | Descriptor destination address |
| ins_cnt | input | CW | Descriptor byte count |
| done_in | input | 1 | Completion from the data path |
| exec_go | output | 1 | One-cycle start pulse to the data path |
| exec_op | output | OP_W | Accepted opcode |
| exec_src | output | AW | Accepted source address |
| exec_dst | output | AW | Accepted destination address |
| exec_cnt | output | CW | Accepted byte count |
| exec_abort | output | 1 | Abort pulse on a soft reset while busy |
| fifo_flush | output | 1 | FIFO flush pulse on a soft reset |

## Verification
The bench targets these corner cases:
- Opcodes at both edges of the legal range (0, NUM_OPS and NUM_OPS+1), and misalignment in one descriptor field at a time. A range check that is off by one, or a missing field check, would leave the channel busy where it should report an error.
- Descriptors offered while the channel is busy or in error. A design that ignores the state would start work twice or escape the error state.
- A soft reset issued while busy and while in error. This reset must wipe the flags and the tag but keep the role and scratch bits, and must flush exactly once. A design that clears too much, too little or for too long shows a wrong word or an extra pulse.
- An all-ones write, and an asynchronous master reset taken in the middle of traffic. Together these expose writable reserved bits and fields that the master reset misses.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_ERR  = 2'b10
  } chan_state_e;

  localparam int B_CHAIN  = 8;
  localparam int B_COUPLE = 9;
  localparam int B_SLAVE  = 10;
  localparam int B_SRST   = 16;
endpackage

// File: rtl/chan_desc_check.sv
module chan_desc_check #(
  parameter int OP_W      = 4,
  parameter int NUM_OPS   = 5,
  parameter int ALIGN_LSB = 2
) (
  input  logic [OP_W-1:0]      op,
  input  logic [ALIGN_LSB-1:0] src_lo,
  input  logic [ALIGN_LSB-1:0] dst_lo,
  input  logic [ALIGN_LSB-1:0] cnt_lo,
  output logic                 bad_op,
  output logic                 bad_align
);
  always_comb begin
    bad_op    = (op == '0) || (int'(op) > NUM_OPS);
    bad_align = (|src_lo) || (|dst_lo) || (|cnt_lo);
  end
endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
  import chan_pkg::*;
(
  input  logic        clk,
  input  logic        mrst_n,
  input  logic        soft_rst,
  input  logic        go_ok,
  input  logic        go_bad,
  input  logic        cfg_err,
  input  logic        done_in,
  output chan_state_e state_q
);
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      state_q <= ST_IDLE;
    end else if (soft_rst) begin
      state_q <= ST_IDLE;
    end else if (cfg_err || go_bad) begin
      state_q <= ST_ERR;
    end else begin
      case (state_q)
        ST_IDLE: if (go_ok)   state_q <= ST_BUSY;
        ST_BUSY: if (done_in) state_q <= ST_IDLE;
        default: state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/chan_csr.sv
module chan_csr
  import chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [B_SRST:0]   wlo,
  input  logic              set_dec,
  input  logic              set_aln,
  input  logic              set_done,
  input  chan_state_e       state_q,
  output logic              soft_rst,
  output logic              cfg_err,
  output logic [2:0]        err_flags,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              fifo_flush,
  output logic              exec_abort
);
  logic       hit;
  logic [7:0] tag_q;
  logic [2:0] role_q;
  logic [4:0] scr_q;
  logic       f_cfg, f_dec, f_aln, f_done;
  logic [REG_W-1:0] view;

  always_comb begin
    hit      = (bus_addr == '0);
    soft_rst = bus_we && hit && wlo[B_SRST];
    cfg_err  = bus_we && hit && !wlo[B_SRST] &&
               (wlo[B_CHAIN] || (wlo[B_COUPLE] && wlo[B_SLAVE]));
    view     = {state_q, 2'b00, f_cfg, f_dec, f_aln, f_done,
                7'b0, 1'b0, scr_q, role_q, tag_q};
    err_flags = {f_cfg, f_dec, f_aln};
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      tag_q  <= '0;
      role_q <= '0;
      scr_q  <= '0;
      f_cfg  <= 1'b0;
      f_dec  <= 1'b0;
      f_aln  <= 1'b0;
      f_done <= 1'b0;
    end else if (soft_rst) begin
      tag_q  <= '0;
      f_cfg  <= 1'b0;
      f_dec  <= 1'b0;
      f_aln  <= 1'b0;
      f_done <= 1'b0;
    end else begin
      if (bus_we && hit) begin
        tag_q  <= wlo[7:0];
        role_q <= wlo[B_SLAVE:B_CHAIN];
        scr_q  <= wlo[15:11];
      end
      f_cfg  <= f_cfg  | cfg_err;
      f_dec  <= f_dec  | set_dec;
      f_aln  <= f_aln  | set_aln;
      f_done <= f_done | set_done;
    end
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      bus_rdata  <= '0;
      fifo_flush <= 1'b0;
      exec_abort <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= hit ? view : '0;
      fifo_flush <= soft_rst;
      exec_abort <= soft_rst && (state_q == ST_BUSY);
    end
  end
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int OP_W      = 4,
  parameter int NUM_OPS   = 5,
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [AW-1:0]     ins_src,
  input  logic [AW-1:0]     ins_dst,
  input  logic [CW-1:0]     ins_cnt,
  input  logic              done_in,
  output logic              exec_go,
  output logic [OP_W-1:0]   exec_op,
  output logic [AW-1:0]     exec_src,
  output logic [AW-1:0]     exec_dst,
  output logic [CW-1:0]     exec_cnt,
  output logic              exec_abort,
  output logic              fifo_flush
);
  chan_state_e state_q;
  logic bad_op, bad_align, take, go_ok, go_bad;
  logic soft_rst, cfg_err, done_evt;
  logic [2:0] err_flags;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[REG_W-1:B_SRST+1];

  chan_desc_check #(.OP_W(OP_W), .NUM_OPS(NUM_OPS), .ALIGN_LSB(ALIGN_LSB)) u_chk_desc (
    .op(ins_op),
    .src_lo(ins_src[ALIGN_LSB-1:0]),
    .dst_lo(ins_dst[ALIGN_LSB-1:0]),
    .cnt_lo(ins_cnt[ALIGN_LSB-1:0]),
    .bad_op(bad_op),
    .bad_align(bad_align)
  );

  always_comb begin
    ins_ready = (state_q == ST_IDLE);
    take      = ins_valid && ins_ready;
    go_bad    = take && (bad_op || bad_align);
    go_ok     = take && !bad_op && !bad_align;
    done_evt  = done_in && (state_q == ST_BUSY) && !soft_rst && !cfg_err;
  end

  chan_fsm u_fsm (
    .clk(clk), .mrst_n(mrst_n), .soft_rst(soft_rst), .go_ok(go_ok),
    .go_bad(go_bad), .cfg_err(cfg_err), .done_in(done_in), .state_q(state_q)
  );

  chan_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .mrst_n(mrst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .wlo(bus_wdata[B_SRST:0]),
    .set_dec(take && bad_op), .set_aln(take && bad_align), .set_done(done_evt),
    .state_q(state_q), .soft_rst(soft_rst), .cfg_err(cfg_err),
    .err_flags(err_flags), .bus_rdata(bus_rdata),
    .fifo_flush(fifo_flush), .exec_abort(exec_abort)
  );

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      exec_go  <= 1'b0;
      exec_op  <= '0;
      exec_src <= '0;
      exec_dst <= '0;
      exec_cnt <= '0;
    end else begin
      exec_go <= go_ok && !soft_rst && !cfg_err;
      if (go_ok) begin
        exec_op  <= ins_op;
        exec_src <= ins_src;
        exec_dst <= ins_dst;
        exec_cnt <= ins_cnt;
      end
    end
  end
endmodule

// File: rtl/chan_ctrl_chk.sv
module chan_ctrl_chk
  import chan_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int OP_W    = 4,
  parameter int NUM_OPS = 5
) (
  input logic              clk,
  input logic              mrst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [OP_W-1:0]   ins_op,
  input logic              exec_go,
  input logic              fifo_flush,
  input chan_state_e       state_q,
  input logic [2:0]        err_flags,
  input logic              soft_rst
);
  // R1
  go_after_take_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    exec_go |-> $past(ins_valid && ins_ready));

  // R2
  no_go_refused_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (ins_valid && !ins_ready) |=> !exec_go);

  // R3
  dec_err_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (ins_valid && ins_ready && !soft_rst && (ins_op == '0 || int'(ins_op) > NUM_OPS))
    |=> (state_q == ST_ERR && err_flags[1]));

  // R5
  cfg_err_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (bus_we && bus_addr == '0 && !bus_wdata[B_SRST] && bus_wdata[B_CHAIN])
    |=> (state_q == ST_ERR && err_flags[2]));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !soft_rst |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R7
  srst_idle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    soft_rst |=> (state_q == ST_IDLE && err_flags == 3'b000));

  // R7
  srst_bit_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !bus_rdata[B_SRST]);

  // R8
  flush_cause_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    fifo_flush |-> $past(bus_we && bus_addr == '0 && bus_wdata[B_SRST]));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (bus_rdata[23:17] == 7'b0 && bus_rdata[29:28] == 2'b0));
endmodule

bind chan_ctrl chan_ctrl_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W), .NUM_OPS(NUM_OPS)) u_sva (
  .clk(clk), .mrst_n(mrst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ins_valid(ins_valid),
  .ins_ready(ins_ready), .ins_op(ins_op), .exec_go(exec_go),
  .fifo_flush(fifo_flush), .state_q(state_q), .err_flags(err_flags),
  .soft_rst(soft_rst)
);

// File: tb/tb_chan_ctrl.sv
`timescale 1ns/1ps
module tb_chan_ctrl;
  localparam int ADDR_W = 4, OP_W = 4, NUM_OPS = 5, AW = 32, CW = 16;

  logic clk = 1'b0, mrst_n = 1'b0;
  logic bus_we = 0, bus_re = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ins_valid = 0, ins_ready, done_in = 0;
  logic [OP_W-1:0] ins_op = '0, exec_op;
  logic [AW-1:0] ins_src = '0, ins_dst = '0, exec_src, exec_dst;
  logic [CW-1:0] ins_cnt = '0, exec_cnt;
  logic exec_go, exec_abort, fifo_flush;

  int total = 0, bad = 0;

  // model
  logic [1:0] m_state;
  logic [7:0] m_tag;
  logic [2:0] m_role;
  logic [4:0] m_scr;
  logic m_cfg, m_dec, m_aln, m_done;

  always #10 clk = ~clk;

  chan_ctrl #(.ADDR_W(ADDR_W), .OP_W(OP_W), .NUM_OPS(NUM_OPS), .AW(AW), .CW(CW)) dut (
    .clk(clk), .mrst_n(mrst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_op(ins_op), .ins_src(ins_src), .ins_dst(ins_dst),
    .ins_cnt(ins_cnt), .done_in(done_in), .exec_go(exec_go), .exec_op(exec_op),
    .exec_src(exec_src), .exec_dst(exec_dst), .exec_cnt(exec_cnt),
    .exec_abort(exec_abort), .fifo_flush(fifo_flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mview();
    return {m_state, 2'b00, m_cfg, m_dec, m_aln, m_done, 7'b0, 1'b0, m_scr, m_role, m_tag};
  endfunction

  function automatic void mclear_all();
    m_state = 2'b00; m_tag = '0; m_role = '0; m_scr = '0;
    m_cfg = 0; m_dec = 0; m_aln = 0; m_done = 0;
  endfunction

  task automatic wr_at(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
    logic ef, ea;
    ef = 0; ea = 0;
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == '0) begin
      if (d[16]) begin
        ef = 1; ea = (m_state == 2'b01);
        m_tag = '0; m_cfg = 0; m_dec = 0; m_aln = 0; m_done = 0; m_state = 2'b00;
      end else begin
        m_tag = d[7:0]; m_role = d[10:8]; m_scr = d[15:11];
        if (d[8] || (d[9] && d[10])) begin m_cfg = 1; m_state = 2'b10; end
      end
    end
    @(negedge clk);
    bus_we = 0;
    chk({req, " fifo_flush"}, {31'b0, fifo_flush}, {31'b0, ef});
    chk({req, " exec_abort"}, {31'b0, exec_abort}, {31'b0, ea});
  endtask

  task automatic rd_at(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    chk(req, bus_rdata, (a == '0) ? mview() : 32'h0);
  endtask

  task automatic instr(input logic [OP_W-1:0] op, input logic [AW-1:0] s,
                       input logic [AW-1:0] d, input logic [CW-1:0] c, input string req);
    logic take, bop, bal, good;
    @(negedge clk);
    chk({req, " R2 ready"}, {31'b0, ins_ready}, {31'b0, (m_state == 2'b00)});
    ins_valid = 1; ins_op = op; ins_src = s; ins_dst = d; ins_cnt = c;
    take = (m_state == 2'b00);
    bop  = (op == 0) || (int'(op) > NUM_OPS);
    bal  = (s[1:0] != 0) || (d[1:0] != 0) || (c[1:0] != 0);
    good = take && !bop && !bal;
    if (take) begin
      if (bop) m_dec = 1;
      if (bal) m_aln = 1;
      m_state = good ? 2'b01 : 2'b10;
    end
    @(negedge clk);
    ins_valid = 0;
    chk({req, " exec_go"}, {31'b0, exec_go}, {31'b0, good});
    if (good) begin
      chk({req, " R1 exec_src"}, exec_src, s);
      chk({req, " R1 exec_dst"}, exec_dst, d);
      chk({req, " R1 exec_cnt/op"}, {12'b0, exec_op, exec_cnt}, {12'b0, op, c});
    end
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done_in = 1;
    if (m_state == 2'b01) begin m_state = 2'b00; m_done = 1; end
    @(negedge clk);
    done_in = 0;
  endtask

  initial begin
    #(20ns * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mclear_all();
    repeat (3) @(negedge clk);
    // R10 outputs quiet during master reset
    chk("R10 rdata in reset", bus_rdata, 32'h0);
    mrst_n = 1;
    rd_at(0, "R10 reset word");
    chk("R2 ready after reset", {31'b0, ins_ready}, 32'h1);

    // R1 normal flow
    instr(4'd1, 32'h1000, 32'h2000, 16'd64, "R1 good op1");
    rd_at(0, "R1 busy state");
    instr(4'd2, 32'h0, 32'h0, 16'd4, "R2 refused while busy");
    pulse_done();
    rd_at(0, "R1 done flag and idle");
    instr(4'(NUM_OPS), 32'h4, 32'h8, 16'd0, "R3 top legal opcode");
    pulse_done();

    // R3 decode faults
    instr(4'd0, 32'h0, 32'h0, 16'd4, "R3 opcode zero");
    rd_at(0, "R3 decode flag");
    instr(4'd1, 32'h0, 32'h0, 16'd4, "R2 refused in error");
    wr_at(0, 32'h0001_0000, "R7 R8 soft reset from error");
    rd_at(0, "R7 after soft reset");
    instr(4'(NUM_OPS + 1), 32'h0, 32'h0, 16'd4, "R3 opcode above range");
    rd_at(0, "R3 decode flag high op");
    wr_at(0, 32'h0001_0000, "R7 soft reset");

    // R4 alignment, one field at a time
    instr(4'd1, 32'h1, 32'h0, 16'd4, "R4 src misaligned");
    rd_at(0, "R4 align flag");
    wr_at(0, 32'h0001_0000, "R7 soft reset");
    instr(4'd1, 32'h0, 32'h2, 16'd4, "R4 dst misaligned");
    wr_at(0, 32'h0001_0000, "R7 soft reset");
    instr(4'd1, 32'h0, 32'h0, 16'd6, "R4 count not multiple of 4");
    rd_at(0, "R4 align flag count");
    wr_at(0, 32'h0001_0000, "R7 soft reset");

    // R5 role faults
    wr_at(0, 32'h0000_0100, "R5 chaining master");
    rd_at(0, "R5 cfg flag");
    wr_at(0, 32'h0000_0000, "R6 write does not clear flag");
    pulse_done();
    rd_at(0, "R6 flag still set");
    wr_at(0, 32'h0001_0000, "R7 soft reset");
    wr_at(0, 32'h0000_0600, "R5 couple and slave");
    rd_at(0, "R5 cfg flag pair");
    wr_at(0, 32'h0001_0000, "R7 soft reset");
    wr_at(0, 32'h0000_0200, "R5 couple only legal");
    rd_at(0, "R5 no flag");

    // R7 partial reset keeps role/scratch, R8 abort when busy
    wr_at(0, 32'h0000_A2C3, "R7 load fields");
    instr(4'd3, 32'h10, 32'h20, 16'd8, "R1 start before abort");
    wr_at(0, 32'h0001_FFFF, "R8 soft reset while busy");
    rd_at(0, "R7 kept bits 15:8");

    // R9 reserved and read-only bits
    wr_at(0, 32'hFFFE_F8FF, "R9 all-ones write");
    rd_at(0, "R9 reserved read zero");

    // R11 other addresses
    wr_at(4'd3, 32'h0000_0100, "R11 write elsewhere");
    rd_at(0, "R11 word untouched");
    rd_at(4'd5, "R11 other address zero");

    // constrained random traffic
    for (int i = 0; i < 2500; i++) begin
      int r;
      logic [31:0] d;
      r = int'($urandom % 16);
      if (r < 5) begin
        logic [OP_W-1:0] op;
        logic [AW-1:0] s, t;
        logic [CW-1:0] c;
        op = OP_W'($urandom % 8);
        s = $urandom; t = $urandom; c = CW'($urandom);
        if ($urandom % 4 != 0) begin s[1:0] = 0; t[1:0] = 0; c[1:0] = 0; end
        instr(op, s, t, c, "R1 R3 R4 random descriptor");
      end else if (r < 7) begin
        pulse_done();
      end else if (r < 9) begin
        d = $urandom; d[16] = 0; d[8] = ($urandom % 6 == 0);
        wr_at(0, d, "R5 R6 random write");
      end else if (r == 9) begin
        d = $urandom; d[16] = 1;
        wr_at(0, d, "R7 R8 random soft reset");
      end else if (r < 15) begin
        rd_at(0, "R6 R9 random read");
      end else begin
        rd_at(ADDR_W'($urandom), "R11 random address read");
      end
    end

    // R10 asynchronous master reset mid-run
    wr_at(0, 32'h0000_7E55, "R10 preload");
    instr(4'd1, 32'h0, 32'h0, 16'd4, "R10 preload busy");
    @(negedge clk);
    #3 mrst_n = 0;
    #2;
    chk("R10 async clear go/flush", {30'b0, exec_go, fifo_flush}, 32'h0);
    mclear_all();
    @(negedge clk);
    mrst_n = 1;
    rd_at(0, "R10 word cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule